// File: doc/BRIEF.md
# Phase-Selectable Programmable Clock Divider

The block models the output counter stage of a clock-management unit. It runs from a single oversampling clock that ticks eight times per oscillator period, so one tick is one 45° step of the oscillator. From that clock it builds eight oscillator phase taps at 45° spacing. These taps start in ring order after reset.

Each of four identical output channels picks one tap and divides it by an integer ratio. A channel can also hold its output low for a whole number of oscillator cycles before the first edge. Two channels with the same ratio can therefore be skewed by any number of 45° steps, and the skew can exceed one oscillator period.

Configuration is captured only while reset is held. All timing is counted in ticks, so the phase relationship between outputs is fixed in phase steps whatever the oscillator rate is.

Top module: `phase_clk_divider`

## Requirements
- R1: Tap k (k = 0..7, bit k of `phase_tap_o`) runs in steady state with an 8-tick period. It is high for the 4 ticks whose index t satisfies ((t - k) mod 8) < 4. Here t = 0 is the first clock edge at which `rst_n` is sampled high.
- R2: After reset release no tap is high before its first rise. Tap k first rises at tick k, so the taps come up in order 0, 1, ..., 7.
- R3: With an even ratio N, a channel output has a period of 8·N ticks and stays high for 4·N ticks. Every rising edge coincides with a rising edge of the selected tap.
- R4: With an odd ratio N ≥ 3, a channel output is high for 4·(N+1) ticks and low for 4·(N-1) ticks in each period of 8·N ticks.
- R5: A ratio of 1 passes the selected tap through unchanged once the start delay has elapsed.
- R6: Two channels with the same ratio and delay but taps k1 and k2 rise (k2 - k1) ticks apart. The 180° tap (index 4) at ratio 2 is half an oscillator period (4 ticks) behind the 0° tap.
- R7: A delay of D oscillator cycles holds the output low until tick k + 8·D, and the first rise falls on that tick. One cycle of delay shifts the output by exactly 8 ticks, and the tap shift adds on top of it.
- R8: All channels behave identically. The same configuration on every channel gives identical outputs on every tick.
- R9: While reset is held, all taps and outputs are low. The configuration inputs are sampled only during reset, and changing them while running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_os | input | 1 | Oversampling clock, eight ticks per oscillator period |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_tap | input | NCH*3 | Per-channel tap index, channel c in bits [3c+2:3c] |
| cfg_div | input | NCH*DIV_W | Per-channel divide ratio (1..2^DIV_W-1), channel c in slice c |
| cfg_dly | input | NCH*DLY_W | Per-channel start delay in oscillator cycles, channel c in slice c |
| phase_tap_o | output | 8 | The eight oscillator phase taps, bit k = k·45° |
| clk_out | output | NCH | Divided clock, one bit per channel |

## Verification
The bench goes after the boundaries of a phase step. A design with an off-by-one in the tap-to-channel alignment would shift every output by one tick and break the 4-tick spacing between the 0° and 180° channels. A design with a wrong delay count would rise 8 ticks early or late. The bench also covers the odd-ratio duty cycle, where a flipped rounding gives a high phase that is one oscillator cycle too short, and the ratio-1 pass-through, where a generic divider would produce a constant level. A late tap such as 7, combined with a multi-cycle delay, exposes designs that let a tap glitch high before its first proper rise. Configuration changes applied mid-run catch a design that samples its settings outside reset.

// File: rtl/pcd_pkg.sv
// Shared constants and types for the phase-selectable clock divider.
// Assumes eight phase taps per oscillator period; one tick = 45 degrees.
package pcd_pkg;
    localparam int NPH  = 8;
    localparam int PH_W = 3;
    localparam int HALF = NPH / 2;
    typedef logic [PH_W-1:0] ph_t;
endpackage

// File: rtl/pcd_phase_ring.sv
// Generates the eight oscillator phase taps from the oversampling clock.
// A tick counter walks 0..7 after reset; tap k is high for the half period
// starting at count k, and is masked until its first rise so the taps come
// up strictly in ring order. Assumes a synchronous active-low reset.
module pcd_phase_ring
    import pcd_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    output ph_t            ph_o,
    output logic [NPH-1:0] tap_o
);
    logic           act;
    ph_t            ph;
    logic [NPH-1:0] seen;

    // Tick counter: parks at the last phase in reset so tick 0 follows release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            ph  <= ph_t'(NPH - 1);
        end else begin
            act <= 1'b1;
            ph  <= ph + ph_t'(1);
        end
    end

    // Start mask: records that each tap has had its first rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
        end else begin
            for (int k = 0; k < NPH; k++) begin
                if (act && ph == ph_t'(k)) seen[k] <= 1'b1;
            end
        end
    end

    // Tap decode: high during the half period that begins at its own index.
    always_comb begin
        for (int k = 0; k < NPH; k++) begin
            tap_o[k] = act && (seen[k] || ph == ph_t'(k))
                       && (ph_t'(ph - ph_t'(k)) < ph_t'(HALF));
        end
    end

    assign ph_o = ph;

    AST_PH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> ph == ph_t'($past(ph) + ph_t'(1))) else $error("phase step"); // R1

    AST_TAP_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (&seen) |-> $countones(tap_o) == HALF) else $error("tap count"); // R1

    for (genvar k = 1; k < NPH; k++) begin : g_order
        AST_TAP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tap_o[k]) |-> tap_o[k-1]) else $error("tap order"); // R2
    end
endmodule

// File: rtl/pcd_out_channel.sv
// One output channel: selects a phase tap, waits a whole number of
// oscillator cycles, then divides the tap by an integer ratio. Counters
// advance on the tick before each cycle boundary of the selected tap, so
// the state is current when the tap rises. Configuration is latched only
// while reset is held; ratio 0 behaves as ratio 1.
module pcd_out_channel
    import pcd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DLY_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ph_t              ph_i,
    input  logic [NPH-1:0]   tap_i,
    input  ph_t              sel_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             clk_o
);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    ph_t              sel_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] ncnt;
    logic [DIV_W-1:0] hi;
    logic [DLY_W-1:0] dleft;
    logic             go;
    logic             one;
    logic             pre;

    assign one = (div_q <= DIV_ONE);
    assign hi  = (div_q >> 1) + DIV_W'(div_q[0]);
    assign pre = (ph_i == ph_t'(sel_q - ph_t'(1)));

    // Configuration capture: follows the inputs only while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= sel_i;
            div_q <= div_i;
        end
    end

    // Delay and divide counters, stepped once per oscillator cycle of the tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go    <= 1'b0;
            dleft <= dly_i;
            ncnt  <= '0;
        end else if (pre) begin
            if (!go) begin
                if (dleft == '0) go <= 1'b1;
                else             dleft <= dleft - DLY_ONE;
                ncnt <= '0;
            end else if (one || ncnt >= div_q - DIV_ONE) begin
                ncnt <= '0;
            end else begin
                ncnt <= ncnt + DIV_ONE;
            end
        end
    end

    // Output decode: tap pass-through at ratio 1, else high for the first hi cycles.
    always_comb begin
        clk_o = go && (one ? tap_i[sel_q] : (ncnt < hi));
    end

    AST_RISE_ON_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_o) |-> $rose(tap_i[sel_q])) else $error("rise off tap"); // R3

    AST_NCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !one |-> ncnt < div_q) else $error("count range"); // R3

    AST_FALL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_o) && !one) |-> ph_i == sel_q) else $error("fall off boundary"); // R4

    AST_HOLD_IN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (dleft != '0) |-> !clk_o) else $error("early output"); // R7
endmodule

// File: rtl/phase_clk_divider.sv
// Top level: one phase ring feeding NCH identical output channels.
// Assumes configuration is stable while rst_n is low for at least one tick.
module phase_clk_divider
    import pcd_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DIV_W = 8,
    parameter int DLY_W = 6
) (
    input  logic                 clk_os,
    input  logic                 rst_n,
    input  logic [NCH*PH_W-1:0]  cfg_tap,
    input  logic [NCH*DIV_W-1:0] cfg_div,
    input  logic [NCH*DLY_W-1:0] cfg_dly,
    output logic [NPH-1:0]       phase_tap_o,
    output logic [NCH-1:0]       clk_out
);
    ph_t ph;

    pcd_phase_ring u_ring (
        .clk   (clk_os),
        .rst_n (rst_n),
        .ph_o  (ph),
        .tap_o (phase_tap_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pcd_out_channel #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_ch (
            .clk   (clk_os),
            .rst_n (rst_n),
            .ph_i  (ph),
            .tap_i (phase_tap_o),
            .sel_i (cfg_tap[c*PH_W +: PH_W]),
            .div_i (cfg_div[c*DIV_W +: DIV_W]),
            .dly_i (cfg_dly[c*DLY_W +: DLY_W]),
            .clk_o (clk_out[c])
        );
    end

    AST_IDLE_IN_RESET: assert property (@(posedge clk_os)
        (!rst_n && $past(!rst_n)) |-> (clk_out == '0 && phase_tap_o == '0))
        else $error("active in reset"); // R9
endmodule

// File: tb/tb_phase_clk_divider.sv
module tb_phase_clk_divider;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4, DIV_W = 8, DLY_W = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NCH*3-1:0]     cfg_tap = '0;
    logic [NCH*DIV_W-1:0] cfg_div = '0;
    logic [NCH*DLY_W-1:0] cfg_dly = '0;
    logic [7:0]           phase_tap_o;
    logic [NCH-1:0]       clk_out;

    phase_clk_divider #(.NCH(NCH), .DIV_W(DIV_W), .DLY_W(DLY_W)) dut (
        .clk_os(clk), .rst_n(rst_n), .cfg_tap(cfg_tap), .cfg_div(cfg_div),
        .cfg_dly(cfg_dly), .phase_tap_o(phase_tap_o), .clk_out(clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0, n_fail = 0, t = -1, cyc = 0;
    int mk[NCH], mn[NCH], md[NCH], first_rise[NCH];
    logic [NCH-1:0] prev_out;
    string tag_over = "";
    bit same_cfg = 0;

    task automatic check(string tag, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s t=%0d actual=%0d expected=%0d", tag, what, t, act, exp);
        end
    endtask

    function automatic int exp_tap(int tt, int k);
        if (tt < k) return 0;
        return (((tt - k) % 8) < 4) ? 1 : 0;
    endfunction

    function automatic int exp_ch(int tt, int k, int n, int d);
        int s, p, h;
        s = k + 8 * d;
        if (tt < s) return 0;
        p = (tt - s) % (8 * n);
        h = (n == 1) ? 4 : 8 * ((n + 1) / 2);
        return (p < h) ? 1 : 0;
    endfunction

    task automatic drive(int c, int k, int n, int d);
        cfg_tap[c*3 +: 3]         = 3'(k);
        cfg_div[c*DIV_W +: DIV_W] = DIV_W'(n);
        cfg_dly[c*DLY_W +: DLY_W] = DLY_W'(d);
    endtask

    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", int'(phase_tap_o), 0, "taps in reset");
        check("R9", int'(clk_out), 0, "outputs in reset");
        for (int c = 0; c < NCH; c++) begin
            mk[c] = int'(cfg_tap[c*3 +: 3]);
            mn[c] = int'(cfg_div[c*DIV_W +: DIV_W]);
            md[c] = int'(cfg_dly[c*DLY_W +: DLY_W]);
            first_rise[c] = -1;
        end
        prev_out = '0;
        t = -1;
        rst_n = 1'b1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            t++;
            @(negedge clk);
            for (int k = 0; k < 8; k++)
                check(t < 8 ? "R2" : "R1", int'(phase_tap_o[k]), exp_tap(t, k), $sformatf("tap%0d", k));
            for (int c = 0; c < NCH; c++) begin
                string tg;
                if (tag_over != "")   tg = tag_over;
                else if (mn[c] == 1)  tg = "R5";
                else if (mn[c] % 2)   tg = "R4";
                else                  tg = "R3";
                check(tg, int'(clk_out[c]), exp_ch(t, mk[c], mn[c], md[c]), $sformatf("ch%0d", c));
                if (same_cfg) check("R8", int'(clk_out[c]), int'(clk_out[0]), $sformatf("ch%0d vs ch0", c));
                if (clk_out[c] && !prev_out[c] && first_rise[c] < 0) first_rise[c] = t;
            end
            prev_out = clk_out;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        // Scenario 1: 0/180 degree ratio 2, ratio 3 with and without one-cycle delay.
        drive(0, 0, 2, 0); drive(1, 4, 2, 0); drive(2, 0, 3, 0); drive(3, 0, 3, 1);
        start();
        run(200);
        check("R6", first_rise[1] - first_rise[0], 4, "180 vs 0 skew");
        check("R7", first_rise[3] - first_rise[2], 8, "one cycle delay skew");

        // Scenario 2: pass-through, late tap with delay, ratio 5, ratio 4 beyond one period.
        drive(0, 2, 1, 0); drive(1, 7, 5, 2); drive(2, 3, 4, 3); drive(3, 6, 1, 1);
        start();
        run(120);
        check("R7", first_rise[2], 27, "tap3 delay3 first rise");
        check("R7", first_rise[1], 23, "tap7 delay2 first rise");
        check("R5", first_rise[0], 2, "pass-through first rise");
        // R9: change configuration while running; outputs must keep old settings.
        drive(0, 5, 6, 9); drive(1, 1, 2, 0); drive(2, 0, 7, 4); drive(3, 3, 3, 2);
        tag_over = "R9";
        run(150);
        tag_over = "";

        // Scenario 3: identical settings on every channel.
        for (int c = 0; c < NCH; c++) drive(c, 5, 3, 1);
        same_cfg = 1;
        start();
        run(120);
        same_cfg = 0;
        check("R6", first_rise[0], 13, "tap5 delay1 first rise");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule